// File: doc/BRIEF.md
# TTY-Stream Character Display Controller

The block keeps a text screen of 16 rows by 64 columns in an internal character store and updates it only from a stream of bytes delivered one at a time, the way a teletype receives them. Each printable byte lands at a hardware cursor, which then advances. A small set of control codes moves the cursor, rings a bell or clears the screen. A line feed on the bottom row scrolls the whole screen up by one line.

Bytes enter through a valid/ready handshake. Scrolling and clearing walk the store one cell per clock, and the controller refuses input and raises `busy_o` for the whole walk. The screen is not memory-mapped. A display scanner reads cells through a separate row/column read port. It also gets the cursor position, and bit 7 of each cell marks the cell for half-brightness rendering.

Top module: `tty_display`

## Requirements
- R1: After reset, the block walks the whole store for exactly ROWS*COLS cycles, writing the blank code 0x20 to every cell. During the walk `busy_o` is 1 and `ready_o` is 0. The cursor is at row 0, column 0.
- R2: A byte whose bits 6:0 are 0x20 or above is printable. All 8 bits of it, including the bit-7 half-brightness attribute, are stored at the cursor cell. The cursor column then increments.
- R3: A printable byte accepted at column COLS-1 is stored there. The cursor then moves to column 0 of the next row. On the last row it scrolls instead (as in R5) and the cursor goes to column 0 of the last row.
- R4: Carriage return (bits 6:0 = 0x0D) sets the column to 0 and leaves the row unchanged.
- R5: Line feed (0x0A) increments the row and keeps the column. On the last row, each row takes the contents of the row below it and the bottom row is blanked to 0x20. This walk keeps `busy_o` high for exactly ROWS*COLS cycles, and the cursor stays on the last row.
- R6: Horizontal tab (0x09) moves the cursor to the next column that is a multiple of 8, capped at column COLS-1. At column COLS-1 the cursor stays put.
- R7: Backspace (0x08) moves the cursor one column left and stops at column 0.
- R8: Bell (0x07) makes `bell_o` 1 for exactly the one cycle after acceptance. It writes no cell and leaves the cursor where it is. `bell_o` is 0 at all other times.
- R9: Home (0x0C) puts the cursor at row 0, column 0 and blanks every cell to 0x20. The walk keeps `busy_o` high for exactly ROWS*COLS cycles.
- R10: Any other byte with bits 6:0 below 0x20 is ignored: no cell is written and the cursor does not move.
- R11: `ready_o` is 0 whenever `busy_o` is 1, and the cursor does not move while busy. `rd_data_o` shows the cell at (`rd_row_i`, `rd_col_i`) one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_i | input | 8 | Incoming byte |
| valid_i | input | 1 | Byte on char_i is offered |
| ready_o | output | 1 | Byte is accepted when valid_i and ready_o are both 1 |
| busy_o | output | 1 | Clear or scroll walk in progress |
| bell_o | output | 1 | One-cycle bell pulse |
| cur_row_o | output | 4 | Cursor row |
| cur_col_o | output | 6 | Cursor column |
| rd_row_i | input | 4 | Scanner read row |
| rd_col_i | input | 6 | Scanner read column |
| rd_data_o | output | 8 | Stored cell, registered |

## Verification
The assertions check the cursor response to each accepted control code on every cycle: carriage return, backspace at and away from column 0, the tab landing column and home. They also check the bell pulse and its absence, the start of a scroll on the last row, and that the cursor does not move and no new walk starts while busy. Only the bench scenarios can show what a walk leaves in the store. Rows must move up by one with the bottom row blanked, a wrapped character must survive its own scroll, and home must erase everything. The bench also measures that each walk lasts exactly ROWS*COLS cycles.

// File: rtl/tty_pkg.sv
package tty_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_PRINT, K_CR, K_LF, K_HT, K_BS, K_BEL, K_HOME
  } kind_e;

  typedef enum logic [1:0] {W_IDLE, W_CLEAR, W_SCROLL} walk_e;

  localparam logic [7:0] BLANK    = 8'h20;
  localparam logic [6:0] C_BEL    = 7'h07;
  localparam logic [6:0] C_BS     = 7'h08;
  localparam logic [6:0] C_HT     = 7'h09;
  localparam logic [6:0] C_LF     = 7'h0A;
  localparam logic [6:0] C_HOME   = 7'h0C;
  localparam logic [6:0] C_CR     = 7'h0D;
  localparam logic [6:0] C_FIRST  = 7'h20;
endpackage

// File: rtl/tty_decode.sv
module tty_decode
  import tty_pkg::*;
(
  input  logic [6:0] code_i,
  output kind_e      kind_o
);
  always_comb begin
    if (code_i >= C_FIRST) begin
      kind_o = K_PRINT;
    end else begin
      unique case (code_i)
        C_CR:    kind_o = K_CR;
        C_LF:    kind_o = K_LF;
        C_HT:    kind_o = K_HT;
        C_BS:    kind_o = K_BS;
        C_BEL:   kind_o = K_BEL;
        C_HOME:  kind_o = K_HOME;
        default: kind_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tty_cursor.sv
module tty_cursor
  import tty_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 64,
  parameter int TAB_STOP = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int TW = $clog2(TAB_STOP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  kind_e         kind_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          wr_o,
  output logic          scroll_o,
  output logic          clear_o
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  logic [RW-1:0] row_n;
  logic [CW-1:0] col_n;
  logic [CW:0]   tab_n;
  logic          last_row;

  assign last_row = (row_o == LAST_ROW);
  assign tab_n    = ((({1'b0, col_o}) >> TW) + (CW+1)'(1)) << TW;

  always_comb begin
    row_n    = row_o;
    col_n    = col_o;
    wr_o     = 1'b0;
    scroll_o = 1'b0;
    clear_o  = 1'b0;
    if (acc_i) begin
      unique case (kind_i)
        K_PRINT: begin
          wr_o = 1'b1;
          if (col_o == LAST_COL) begin
            col_n = '0;
            if (last_row) scroll_o = 1'b1;
            else          row_n = row_o + 1'b1;
          end else begin
            col_n = col_o + 1'b1;
          end
        end
        K_CR: col_n = '0;
        K_LF: begin
          if (last_row) scroll_o = 1'b1;
          else          row_n = row_o + 1'b1;
        end
        K_HT: col_n = (tab_n > (CW+1)'(COLS - 1)) ? LAST_COL : tab_n[CW-1:0];
        K_BS: if (col_o != '0) col_n = col_o - 1'b1;
        K_HOME: begin
          row_n   = '0;
          col_n   = '0;
          clear_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else begin
      row_o <= row_n;
      col_o <= col_n;
    end
  end

  p_cr_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == K_CR |=> col_o == '0 && row_o == $past(row_o));
  p_bs_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == K_BS && col_o != '0 |=> col_o == $past(col_o) - 1'b1);
  p_bs_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == K_BS && col_o == '0 |=> col_o == '0);
  p_tab_land_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == K_HT |=> (col_o[TW-1:0] == '0 || col_o == LAST_COL)
                                && col_o >= $past(col_o));
  p_home_pos_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == K_HOME |=> row_o == '0 && col_o == '0);
endmodule

// File: rtl/tty_walker.sv
module tty_walker
  import tty_pkg::*;
#(
  parameter int CELLS = 1024,
  localparam int AW = $clog2(CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scroll_i,
  input  logic          clear_i,
  output logic          busy_o,
  output logic          scroll_mode_o,
  output logic [AW-1:0] idx_o
);
  walk_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= W_CLEAR;
      idx_o <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: begin
          idx_o <= '0;
          if (clear_i)       st_q <= W_CLEAR;
          else if (scroll_i) st_q <= W_SCROLL;
        end
        default: begin
          if (idx_o == AW'(CELLS - 1)) begin
            st_q  <= W_IDLE;
            idx_o <= '0;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o        = (st_q != W_IDLE);
  assign scroll_mode_o = (st_q == W_SCROLL);

  p_no_start_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(scroll_i || clear_i));
endmodule

// File: rtl/tty_store.sv
module tty_store #(
  parameter int CELLS = 1024,
  parameter int DW    = 8,
  localparam int AW = $clog2(CELLS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] caddr_i,
  output logic [DW-1:0] cdata_o,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [CELLS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // copy port for scrolling, same-cycle read
  assign cdata_o = mem[caddr_i];
endmodule

// File: rtl/tty_display.sv
module tty_display
  import tty_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 64,
  parameter int TAB_STOP = 8,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int CELLS = ROWS * COLS,
  localparam int AW    = RW + CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    char_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          bell_o,
  output logic [RW-1:0] cur_row_o,
  output logic [CW-1:0] cur_col_o,
  input  logic [RW-1:0] rd_row_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [7:0]    rd_data_o
);
  localparam logic [AW-1:0] KEEP_LIMIT = AW'((ROWS - 1) * COLS);

  kind_e         kind;
  logic          acc, wr_char, scroll_req, clear_req, scroll_mode;
  logic [AW-1:0] idx, waddr, caddr;
  logic [7:0]    wdata, cdata;
  logic          we;

  assign acc     = valid_i && ready_o;
  assign ready_o = !busy_o;

  tty_decode u_decode (.code_i(char_i[6:0]), .kind_o(kind));

  tty_cursor #(.ROWS(ROWS), .COLS(COLS), .TAB_STOP(TAB_STOP)) u_cursor (
    .clk_i, .rst_ni, .acc_i(acc), .kind_i(kind),
    .row_o(cur_row_o), .col_o(cur_col_o),
    .wr_o(wr_char), .scroll_o(scroll_req), .clear_o(clear_req)
  );

  tty_walker #(.CELLS(CELLS)) u_walker (
    .clk_i, .rst_ni, .scroll_i(scroll_req), .clear_i(clear_req),
    .busy_o, .scroll_mode_o(scroll_mode), .idx_o(idx)
  );

  assign caddr = idx + AW'(COLS);

  always_comb begin
    if (busy_o) begin
      we    = 1'b1;
      waddr = idx;
      wdata = (scroll_mode && idx < KEEP_LIMIT) ? cdata : BLANK;
    end else begin
      we    = wr_char;
      waddr = {cur_row_o, cur_col_o};
      wdata = char_i;
    end
  end

  tty_store #(.CELLS(CELLS), .DW(8)) u_store (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .caddr_i(caddr), .cdata_o(cdata),
    .raddr_i({rd_row_i, rd_col_i}), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bell_o <= 1'b0;
    else         bell_o <= acc && kind == K_BEL;
  end

  p_bell_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && kind == K_BEL |=> bell_o);
  p_bell_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && kind == K_BEL) |=> !bell_o);
  p_scroll_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && kind == K_LF && cur_row_o == RW'(ROWS - 1)
    |=> busy_o && cur_row_o == RW'(ROWS - 1) && $stable(cur_col_o));
  p_cursor_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cur_row_o) && $stable(cur_col_o));
  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && kind == K_NONE |=> $stable(cur_row_o) && $stable(cur_col_o) && !busy_o);
  p_print_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && kind == K_PRINT && cur_col_o != CW'(COLS - 1)
    |=> cur_col_o == $past(cur_col_o) + 1'b1 && $stable(cur_row_o));
endmodule

// File: tb/tty_display_tb.sv
module tty_display_tb;
  localparam int ROWS  = 16;
  localparam int COLS  = 64;
  localparam int CELLS = ROWS * COLS;

  // {byte, expected row, expected col} starting from (0,0)
  localparam logic [23:0] VEC [12] = '{
    24'h41_00_01, 24'hC2_00_02, 24'h09_00_08, 24'h08_00_07,
    24'h0D_00_00, 24'h0A_01_00, 24'h01_01_00, 24'h07_01_00,
    24'h09_01_08, 24'h1B_01_08, 24'h08_01_07, 24'h5A_01_08
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] char_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       ready_o, busy_o, bell_o;
  logic [3:0] cur_row_o, rd_row_i = '0;
  logic [5:0] cur_col_o, rd_col_i = '0;
  logic [7:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  tty_display u_dut (
    .clk_i, .rst_ni, .char_i, .valid_i, .ready_o, .busy_o, .bell_o,
    .cur_row_o, .cur_col_o, .rd_row_i, .rd_col_i, .rd_data_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cur(input string tag, input int r, input int c);
    chk(cur_row_o == 4'(r) && cur_col_o == 6'(c), tag,
        {cur_row_o, 2'b00, cur_col_o}, (r << 8) | c);
  endtask

  task automatic send(input logic [7:0] b);
    while (!ready_o) @(negedge clk_i);
    char_i  = b;
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic walk(output int cnt, output bit rdy_seen);
    cnt = 0;
    rdy_seen = 1'b0;
    while (busy_o && cnt < CELLS + 16) begin
      if (ready_o) rdy_seen = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      cnt++;
    end
  endtask

  task automatic rd(input int r, input int c, output logic [7:0] d);
    rd_row_i = 4'(r);
    rd_col_i = 6'(c);
    @(posedge clk_i);
    @(negedge clk_i);
    d = rd_data_o;
  endtask

  task automatic chk_cell(input string tag, input int r, input int c, input logic [7:0] e);
    logic [7:0] d;
    rd(r, c, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic chk_walk(input string tag);
    int  cnt;
    bit  rs;
    chk(busy_o && !ready_o, {tag, " busy"}, {busy_o, ready_o}, 2'b10);
    walk(cnt, rs);
    chk(cnt == CELLS && !rs, {tag, " walk length"}, cnt, CELLS);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset clear
    chk_cur("R1 cursor at reset", 0, 0);
    chk(bell_o == 1'b0, "R1 bell idle", bell_o, 0);
    chk_walk("R1 reset");
    chk_cell("R1 blank cell", 5, 33, 8'h20);

    // vector table from home position
    foreach (VEC[i]) begin
      logic [7:0] b;
      b = VEC[i][23:16];
      send(b);
      chk_cur($sformatf("R2/R4/R6/R7/R10 vector %0d", i), VEC[i][15:8], VEC[i][7:0]);
      chk(bell_o == (b == 8'h07), $sformatf("R8 bell vector %0d", i), bell_o, b == 8'h07);
    end
    @(negedge clk_i);
    chk(bell_o == 1'b0, "R8 bell single cycle", bell_o, 0);
    chk_cell("R2 plain char", 0, 0, 8'h41);
    chk_cell("R2 attribute kept", 0, 1, 8'hC2);
    chk_cell("R6 tab writes nothing", 0, 2, 8'h20);
    chk_cell("R8 R10 no write", 1, 0, 8'h20);
    chk_cell("R2 after backspace", 1, 7, 8'h5A);

    // tab cap and wrap
    send(8'h0D);
    for (int k = 0; k < 7; k++) send(8'h09);
    chk_cur("R6 tab to 56", 1, 56);
    send(8'h09);
    chk_cur("R6 tab capped", 1, 63);
    send(8'h09);
    chk_cur("R6 tab at last column", 1, 63);
    send(8'h57);
    chk_cur("R3 wrap to next row", 2, 0);
    chk_cell("R3 last column stored", 1, 63, 8'h57);
    send(8'h08);
    chk_cur("R7 backspace at column 0", 2, 0);

    // line feeds down to last row, then scroll
    for (int k = 0; k < 13; k++) send(8'h0A);
    chk_cur("R5 line feed keeps column", 15, 0);
    send(8'h51);
    send(8'h0A);
    chk_cur("R5 scroll cursor", 15, 1);
    chk_walk("R5 scroll");
    chk_cell("R5 row moved up", 0, 7, 8'h5A);
    chk_cell("R5 row moved up end", 0, 63, 8'h57);
    chk_cell("R5 old top row gone", 0, 0, 8'h20);
    chk_cell("R5 bottom to row 14", 14, 0, 8'h51);
    chk_cell("R5 bottom blanked", 15, 0, 8'h20);

    // wrap on last row
    send(8'h0D);
    for (int k = 0; k < 8; k++) send(8'h09);
    chk_cur("R6 last row to column 63", 15, 63);
    send(8'h52);
    chk_cur("R3 wrap scroll cursor", 15, 0);
    chk_walk("R3 wrap scroll");
    chk_cell("R3 wrapped char scrolled", 14, 63, 8'h52);
    chk_cell("R3 bottom blanked", 15, 63, 8'h20);
    chk_cell("R3 second scroll", 13, 0, 8'h51);

    // home
    send(8'h0C);
    chk_cur("R9 home cursor", 0, 0);
    chk_walk("R9 home");
    chk_cell("R9 cleared", 13, 0, 8'h20);
    chk_cell("R9 cleared top", 0, 7, 8'h20);
    send(8'hC1);
    chk_cur("R11 accepts after walk", 0, 1);
    chk_cell("R11 read port", 0, 0, 8'hC1);

    finish_run();
  end
endmodule